// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This unit sits between the register file and a 32-bit memory bus. For every load or store it forms the byte address from a base register value and an offset. The offset is either a zero-extended immediate or a second register value, and it can be added to or subtracted from the base. In pre-indexed form the access goes to the offset address, and that address can also be written back to the base register. In post-indexed form the access goes to the unmodified base, and the offset address is always written back.

The unit maps byte, halfword and word accesses onto the four byte lanes of the bus. It produces byte enables, replicates store data across the lanes, and pulls load data out of the returned bus word with zero extension. The byte order inside a word is little-endian or big-endian. That choice is sampled from a configuration pin only while reset is asserted, and it then stays fixed until the next reset.

The unit has a fixed pipeline. A request is presented for one cycle. After the next rising edge the registered access outputs are valid: address, byte enables, write flag, store data and writeback. The memory returns read data during that cycle, and the extracted load value is valid after the following edge.

Top module: `lsu_lane_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `acc_req`, `acc_we`, `acc_be`, `wb_en` and `ld_valid` are 0, and `acc_addr`, `acc_wdata`, `wb_value` and `ld_data` are 0.
- R2: For a request with `pre_index`=1 and `off_sub`=0, `acc_addr` one cycle later equals `base + off`. `off` is `reg_off` when `off_is_reg`=1 and the 12-bit `imm_off` zero-extended when it is 0. A zero offset gives `acc_addr` = `base` (register-indirect form).
- R3: With `off_sub`=1 the offset is subtracted (`base - off`, modulo 2^32) for both immediate and register offsets.
- R4: For a pre-indexed request, `wb_en` one cycle later equals `wb_req`. When it is 1, `wb_value` equals `acc_addr`.
- R5: For a post-indexed request (`pre_index`=0), `acc_addr` equals `base` and `wb_en`=1 whatever `wb_req` is. `wb_value` equals `base` plus or minus the offset.
- R6: `size` encodes 00 byte, 01 halfword, 10 or 11 word. In little-endian mode a byte at address bits [1:0]=k enables lane k (`acc_be` = 1<<k). A halfword enables 0011 when address bit 1 is 0 and 1100 when it is 1. A word enables 1111. Halfwords ignore address bit 0 and words ignore bits [1:0].
- R7: In big-endian mode byte k sits on lane 3-k (`acc_be` = 1<<(3-k)). A halfword enables 1100 when address bit 1 is 0 and 0011 when it is 1. A word enables 1111.
- R8: `acc_wdata` carries the low byte of `st_data` copied to all four lanes for byte stores and the low halfword copied to both halves for halfword stores. Word stores carry `st_data` unchanged. `acc_we` equals `is_store`.
- R9: For a load, `ld_valid` is 1 and `ld_data` holds the value of the enabled lanes of `rd_data`, zero-extended, one cycle after `acc_req`. `rd_data` is sampled at the edge that ends the `acc_req` cycle.
- R10: `endian_cfg` is sampled only while `rst` is high (1 = big-endian). Changes on it after reset do not alter the lane mapping.
- R11: A cycle with `req_valid`=0 gives `acc_req`=0, `acc_be`=0, `acc_we`=0 and `wb_en`=0 one cycle later. A store gives `ld_valid`=0 in the cycle after its access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| endian_cfg | input | 1 | Byte order sampled during reset, 1 = big-endian |
| req_valid | input | 1 | Request present this cycle |
| is_store | input | 1 | 1 = store, 0 = load |
| size | input | 2 | Access size (00 byte, 01 half, 1x word) |
| base | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset, zero-extended |
| reg_off | input | 32 | Register offset |
| off_is_reg | input | 1 | Use `reg_off` instead of `imm_off` |
| off_sub | input | 1 | Subtract offset instead of adding |
| pre_index | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| wb_req | input | 1 | Writeback request for pre-indexed form |
| st_data | input | 32 | Register value to store |
| rd_data | input | 32 | Read data from memory during the access cycle |
| acc_req | output | 1 | Access valid on the bus outputs |
| acc_we | output | 1 | Access is a write |
| acc_addr | output | 32 | Byte address |
| acc_be | output | 4 | Byte-lane enables |
| acc_wdata | output | 32 | Lane-replicated store data |
| wb_en | output | 1 | Base register writeback enable |
| wb_value | output | 32 | Value written back to the base register |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Zero-extended load result |

## Verification
The assertions assume that a load's read data is present on `rd_data` during the cycle in which `acc_req` is high. They also assume that `endian_cfg` matters only while reset is held. The bench drives read data on the falling edge inside that cycle and reasserts reset whenever it switches byte order. It then toggles `endian_cfg` outside reset only to show that the change is ignored. Accesses use address bits that match the size where the lane choice depends on them. One halfword and one word case place stray low address bits on purpose, to show that those bits are ignored.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [ADDR_W-1:0] reg_off,
  input  logic              off_is_reg,
  input  logic              off_sub,
  input  logic              pre_index,
  input  logic              wb_req,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [ADDR_W-1:0] upd_addr,
  output logic              wb_fire
);
  localparam int PAD_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] off_val;
  logic [ADDR_W-1:0] moved;

  always_comb begin
    off_val  = off_is_reg ? reg_off : {{PAD_W{1'b0}}, imm_off};
    moved    = off_sub ? (base - off_val) : (base + off_val);
    acc_addr = pre_index ? moved : base;
    upd_addr = moved;
    wb_fire  = pre_index ? wb_req : 1'b1;
  end
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] lane_addr,
  input  acc_size_e                   size,
  input  logic                        big_end,
  input  logic [DATA_W-1:0]           st_val,
  output logic [DATA_W/8-1:0]         lane_en,
  output logic [DATA_W-1:0]           bus_data
);
  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = $clog2(NB);

  logic [LANE_W-1:0] byte_sel;
  logic [LANE_W-1:0] half_base;

  always_comb begin
    byte_sel  = big_end ? ~lane_addr : lane_addr;
    half_base = {byte_sel[LANE_W-1:1], 1'b0};
    case (size)
      SZ_BYTE: begin
        lane_en  = {{(NB-1){1'b0}}, 1'b1} << byte_sel;
        bus_data = {NB{st_val[7:0]}};
      end
      SZ_HALF: begin
        lane_en  = {{(NB-2){1'b0}}, 2'b11} << half_base;
        bus_data = {(NB/2){st_val[15:0]}};
      end
      default: begin
        lane_en  = {NB{1'b1}};
        bus_data = st_val;
      end
    endcase
  end
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] lane_addr,
  input  acc_size_e                   size,
  input  logic                        big_end,
  input  logic [DATA_W-1:0]           bus_word,
  output logic [DATA_W-1:0]           reg_val
);
  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = $clog2(NB);

  logic [LANE_W-1:0] byte_sel;
  logic [LANE_W-1:0] half_base;
  logic [DATA_W-1:0] shifted_b;
  logic [DATA_W-1:0] shifted_h;

  always_comb begin
    byte_sel  = big_end ? ~lane_addr : lane_addr;
    half_base = {byte_sel[LANE_W-1:1], 1'b0};
    shifted_b = bus_word >> {byte_sel, 3'b000};
    shifted_h = bus_word >> {half_base, 3'b000};
    case (size)
      SZ_BYTE: reg_val = {{(DATA_W-8){1'b0}}, shifted_b[7:0]};
      SZ_HALF: reg_val = {{(DATA_W-16){1'b0}}, shifted_h[15:0]};
      default: reg_val = bus_word;
    endcase
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  endian_cfg,
  input  logic                  req_valid,
  input  logic                  is_store,
  input  logic [1:0]            size,
  input  logic [ADDR_W-1:0]     base,
  input  logic [IMM_W-1:0]      imm_off,
  input  logic [ADDR_W-1:0]     reg_off,
  input  logic                  off_is_reg,
  input  logic                  off_sub,
  input  logic                  pre_index,
  input  logic                  wb_req,
  input  logic [DATA_W-1:0]     st_data,
  input  logic [DATA_W-1:0]     rd_data,
  output logic                  acc_req,
  output logic                  acc_we,
  output logic [ADDR_W-1:0]     acc_addr,
  output logic [DATA_W/8-1:0]   acc_be,
  output logic [DATA_W-1:0]     acc_wdata,
  output logic                  wb_en,
  output logic [ADDR_W-1:0]     wb_value,
  output logic                  ld_valid,
  output logic [DATA_W-1:0]     ld_data
);
  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = $clog2(NB);

  acc_size_e         size_in;
  logic              big_q;
  logic              pre_q;
  acc_size_e         sz_q;
  logic [LANE_W-1:0] lane_q;

  logic [ADDR_W-1:0] ea_acc;
  logic [ADDR_W-1:0] ea_upd;
  logic              ea_wb;
  logic [NB-1:0]     be_c;
  logic [DATA_W-1:0] wdata_c;
  logic [DATA_W-1:0] ext_c;

  assign size_in = acc_size_e'(size);

  lsu_ea_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_ea (
    .base       (base),
    .imm_off    (imm_off),
    .reg_off    (reg_off),
    .off_is_reg (off_is_reg),
    .off_sub    (off_sub),
    .pre_index  (pre_index),
    .wb_req     (wb_req),
    .acc_addr   (ea_acc),
    .upd_addr   (ea_upd),
    .wb_fire    (ea_wb)
  );

  lsu_lane_map #(.DATA_W(DATA_W)) u_map (
    .lane_addr (ea_acc[LANE_W-1:0]),
    .size      (size_in),
    .big_end   (big_q),
    .st_val    (st_data),
    .lane_en   (be_c),
    .bus_data  (wdata_c)
  );

  lsu_load_ext #(.DATA_W(DATA_W)) u_ext (
    .lane_addr (lane_q),
    .size      (sz_q),
    .big_end   (big_q),
    .bus_word  (rd_data),
    .reg_val   (ext_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      big_q     <= endian_cfg;
      acc_req   <= 1'b0;
      acc_we    <= 1'b0;
      acc_addr  <= '0;
      acc_be    <= '0;
      acc_wdata <= '0;
      wb_en     <= 1'b0;
      wb_value  <= '0;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      pre_q     <= 1'b0;
      sz_q      <= SZ_WORD;
      lane_q    <= '0;
    end else begin
      acc_req  <= req_valid;
      ld_valid <= acc_req && !acc_we;
      if (acc_req && !acc_we) ld_data <= ext_c;
      if (req_valid) begin
        acc_we    <= is_store;
        acc_addr  <= ea_acc;
        acc_be    <= be_c;
        acc_wdata <= wdata_c;
        wb_en     <= ea_wb;
        wb_value  <= ea_upd;
        pre_q     <= pre_index;
        sz_q      <= size_in;
        lane_q    <= ea_acc[LANE_W-1:0];
      end else begin
        acc_we <= 1'b0;
        acc_be <= '0;
        wb_en  <= 1'b0;
      end
    end
  end

  // R10
  endian_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(big_q));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_req |-> (acc_be == '0 && !wb_en && !acc_we));

  // R5
  post_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !pre_index) |=> (wb_en && acc_addr == $past(base)));

  // R4
  pre_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && wb_en && pre_q) |-> (wb_value == acc_addr));

  // R6
  byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && sz_q == SZ_BYTE) |-> $countones(acc_be) == 1);

  // R9
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_we) |=> ld_valid);

  // R9
  zext_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && sz_q == SZ_BYTE && !$past(req_valid)) |-> ld_data[DATA_W-1:8] == '0);
endmodule

// File: tb/lsu_lane_unit_test.sv
`timescale 1ns/1ps
module lsu_lane_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        endian_cfg;
  logic        req_valid;
  logic        is_store;
  logic [1:0]  size;
  logic [31:0] base;
  logic [11:0] imm_off;
  logic [31:0] reg_off;
  logic        off_is_reg;
  logic        off_sub;
  logic        pre_index;
  logic        wb_req;
  logic [31:0] st_data;
  logic [31:0] rd_data;
  logic        acc_req;
  logic        acc_we;
  logic [31:0] acc_addr;
  logic [3:0]  acc_be;
  logic [31:0] acc_wdata;
  logic        wb_en;
  logic [31:0] wb_value;
  logic        ld_valid;
  logic [31:0] ld_data;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  lsu_lane_unit uut (
    .clk(clk), .rst(rst), .endian_cfg(endian_cfg), .req_valid(req_valid),
    .is_store(is_store), .size(size), .base(base), .imm_off(imm_off),
    .reg_off(reg_off), .off_is_reg(off_is_reg), .off_sub(off_sub),
    .pre_index(pre_index), .wb_req(wb_req), .st_data(st_data),
    .rd_data(rd_data), .acc_req(acc_req), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .wb_en(wb_en), .wb_value(wb_value), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic big);
    @(negedge clk);
    rst = 1'b1; endian_cfg = big; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one request at a falling edge; outputs are checked at the next falling edge.
  task automatic issue(input logic st, input logic [1:0] sz, input logic [31:0] b,
                       input logic [11:0] imm, input logic [31:0] ro, input logic use_r,
                       input logic sub, input logic pre, input logic wbr, input logic [31:0] sd);
    is_store = st; size = sz; base = b; imm_off = imm; reg_off = ro;
    off_is_reg = use_r; off_sub = sub; pre_index = pre; wb_req = wbr; st_data = sd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic test_reset;
    @(negedge clk);
    rst = 1'b1; endian_cfg = 1'b0; req_valid = 1'b0; rd_data = '0;
    is_store = 0; size = 0; base = 0; imm_off = 0; reg_off = 0;
    off_is_reg = 0; off_sub = 0; pre_index = 1; wb_req = 0; st_data = 0;
    repeat (2) @(negedge clk);
    chk("R1 acc_req", {31'b0, acc_req}, 32'h0);
    chk("R1 acc_be", {28'b0, acc_be}, 32'h0);
    chk("R1 wb_en", {31'b0, wb_en}, 32'h0);
    chk("R1 ld_valid", {31'b0, ld_valid}, 32'h0);
    chk("R1 acc_addr", acc_addr, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release acc_req", {31'b0, acc_req}, 32'h0);
  endtask

  task automatic test_addr;
    issue(1, 2'b10, 32'h0000_1000, 12'h010, 32'h0, 0, 0, 1, 0, 32'h0);
    chk("R2 imm add addr", acc_addr, 32'h0000_1010);
    chk("R4 no wb_req", {31'b0, wb_en}, 32'h0);
    issue(1, 2'b10, 32'h0000_2000, 12'h000, 32'h0000_0124, 1, 0, 1, 0, 32'h0);
    chk("R2 reg add addr", acc_addr, 32'h0000_2124);
    issue(1, 2'b10, 32'h0000_3000, 12'h000, 32'h0, 0, 0, 1, 0, 32'h0);
    chk("R2 indirect addr", acc_addr, 32'h0000_3000);
    issue(1, 2'b10, 32'h0000_0010, 12'h000, 32'h0000_0020, 1, 1, 1, 0, 32'h0);
    chk("R3 reg sub wrap", acc_addr, 32'hFFFF_FFF0);
    issue(1, 2'b10, 32'h0000_0100, 12'h004, 32'h0, 0, 1, 1, 0, 32'h0);
    chk("R3 imm sub", acc_addr, 32'h0000_00FC);
  endtask

  task automatic test_writeback;
    issue(0, 2'b10, 32'h0000_4000, 12'h008, 32'h0, 0, 0, 1, 1, 32'h0);
    chk("R4 pre wb_en", {31'b0, wb_en}, 32'h1);
    chk("R4 pre wb_value", wb_value, 32'h0000_4008);
    chk("R4 pre addr", acc_addr, 32'h0000_4008);
    issue(0, 2'b10, 32'h0000_5000, 12'h000, 32'h0000_0040, 1, 1, 0, 0, 32'h0);
    chk("R5 post addr", acc_addr, 32'h0000_5000);
    chk("R5 post wb_en", {31'b0, wb_en}, 32'h1);
    chk("R5 post wb_value", wb_value, 32'h0000_4FC0);
  endtask

  task automatic test_lanes(input logic big);
    for (int k = 0; k < 4; k++) begin
      issue(1, 2'b00, 32'h0000_8000 + k, 12'h0, 32'h0, 0, 0, 1, 0, 32'h0000_00A5);
      if (big) chk("R7 byte be", {28'b0, acc_be}, 32'h1 << (3 - k));
      else     chk("R6 byte be", {28'b0, acc_be}, 32'h1 << k);
    end
    issue(1, 2'b01, 32'h0000_8001, 12'h0, 32'h0, 0, 0, 1, 0, 32'h0);
    if (big) chk("R7 half low be", {28'b0, acc_be}, 32'hC);
    else     chk("R6 half low be", {28'b0, acc_be}, 32'h3);
    issue(1, 2'b01, 32'h0000_8002, 12'h0, 32'h0, 0, 0, 1, 0, 32'h0);
    if (big) chk("R7 half high be", {28'b0, acc_be}, 32'h3);
    else     chk("R6 half high be", {28'b0, acc_be}, 32'hC);
    issue(1, 2'b10, 32'h0000_8003, 12'h0, 32'h0, 0, 0, 1, 0, 32'h0);
    chk("R6 word be", {28'b0, acc_be}, 32'hF);
  endtask

  task automatic test_store_data;
    issue(1, 2'b00, 32'h0000_0002, 12'h0, 32'h0, 0, 0, 1, 0, 32'h1234_56C3);
    chk("R8 byte replicate", acc_wdata, 32'hC3C3_C3C3);
    chk("R8 we", {31'b0, acc_we}, 32'h1);
    issue(1, 2'b01, 32'h0000_0002, 12'h0, 32'h0, 0, 0, 1, 0, 32'h1234_BEEF);
    chk("R8 half replicate", acc_wdata, 32'hBEEF_BEEF);
    issue(1, 2'b11, 32'h0000_0000, 12'h0, 32'h0, 0, 0, 1, 0, 32'hCAFE_F00D);
    chk("R8 word unchanged", acc_wdata, 32'hCAFE_F00D);
    @(negedge clk);
    chk("R11 store no ld_valid", {31'b0, ld_valid}, 32'h0);
    chk("R11 idle acc_req", {31'b0, acc_req}, 32'h0);
    chk("R11 idle be", {28'b0, acc_be}, 32'h0);
  endtask

  task automatic load_one(input string tag, input logic [1:0] sz, input logic [31:0] a,
                          input logic [31:0] bus, input logic [31:0] exp);
    issue(0, sz, a, 12'h0, 32'h0, 0, 0, 1, 0, 32'h0);
    chk({tag, " we"}, {31'b0, acc_we}, 32'h0);
    rd_data = bus;
    @(negedge clk);
    chk({tag, " valid"}, {31'b0, ld_valid}, 32'h1);
    chk(tag, ld_data, exp);
    rd_data = '0;
  endtask

  task automatic test_loads(input logic big);
    if (!big) begin
      load_one("R9 le byte1", 2'b00, 32'h0000_0101, 32'h4433_2211, 32'h0000_0022);
      load_one("R9 le byte3", 2'b00, 32'h0000_0103, 32'h8833_2211, 32'h0000_0088);
      load_one("R9 le half hi", 2'b01, 32'h0000_0102, 32'hA0B0_C0D0, 32'h0000_A0B0);
      load_one("R9 word", 2'b10, 32'h0000_0100, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    end else begin
      load_one("R9 be byte0", 2'b00, 32'h0000_0100, 32'h4433_2211, 32'h0000_0044);
      load_one("R9 be byte2", 2'b00, 32'h0000_0102, 32'h4433_2211, 32'h0000_0022);
      load_one("R9 be half lo", 2'b01, 32'h0000_0100, 32'hA0B0_C0D0, 32'h0000_A0B0);
      load_one("R9 be half hi", 2'b01, 32'h0000_0102, 32'hA0B0_C0D0, 32'h0000_C0D0);
    end
  endtask

  task automatic test_endian_latch;
    do_reset(1'b1);
    endian_cfg = 1'b0;
    @(negedge clk);
    issue(1, 2'b00, 32'h0000_0000, 12'h0, 32'h0, 0, 0, 1, 0, 32'h0);
    chk("R10 cfg change ignored", {28'b0, acc_be}, 32'h8);
  endtask

  initial begin
    test_reset();
    test_addr();
    test_writeback();
    test_lanes(1'b0);
    test_store_data();
    test_loads(1'b0);
    do_reset(1'b1);
    test_lanes(1'b1);
    test_loads(1'b1);
    test_endian_latch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule